// File: doc/BRIEF.md
# Device-to-Host Status Frame Builder

This block produces the status frames that a serial disk host adapter deposits in a port's receive area. Two frame kinds exist: a 20-byte register frame and an 8-byte set-device-bits frame. A third request kind builds the register frame that follows a port reset, whose echo field is synthesised instead of copied from a command. The block does not know where the receive area sits in memory. It emits (offset, byte) pairs relative to the start of the frame, and a flag that tells the consumer which frame area the bytes belong to.

A request is taken only when the port's frame reception is enabled and the block is idle. On acceptance, the status, error, interrupt-pending flag, echo bytes and completion mask are captured. The frame then streams out one byte per transfer on a valid/ready interface. The byte and offset stay stable while `out_valid` is high and `out_ready` is low. A transfer happens on every clock edge where both are high. Once the last byte has been taken, a one-cycle `done` pulse follows, carrying the interrupt-cause pulses for that frame. Requests are not queued: a request seen while `busy` is high is dropped.

A running completion mask collects the tag bits of every accepted set-device-bits request. Each such frame carries the updated mask, and a clear input empties it. `sdb_tags` is `TAGS` bits wide, with `TAGS` at most 32, and is zero-extended into the 32-bit frame field.

Top module: `d2h_status_framer`

## Requirements
- R1: While `rx_en` is low, any request is ignored: `busy` stays low, no byte, `done` or interrupt pulse appears, and the completion mask keeps its value.
- R2: After a request is accepted on a clock edge, `out_valid` is high from the next cycle with `out_offset` = 0. Offsets rise by one after each transfer (`out_valid` and `out_ready` both high). While `out_ready` is low, `out_valid`, `out_offset` and `out_byte` hold.
- R3: In a register frame, byte 0 is 0x34. Byte 1 is 0x40 when `glb_irq_pend` was high at acceptance and 0x00 otherwise. Byte 2 is the captured status, byte 3 the captured error, and bytes 14 to 19 are 0x00.
- R4: In a register frame built from `req_reg`, byte k for k = 4..13 equals `cmd_echo[(k-4)*8 +: 8]`.
- R5: In the frame built from `req_init`, bytes 4 and 12 are 0x01. Bytes 5 and 6 are 0x14 and 0xEB when `is_optical` is high, and 0x00 otherwise. The other bytes in 4..13 are 0x00. Bytes 0..3 and 14..19 follow R3.
- R6: Every register frame pulses `irq_d2h` in its `done` cycle. `irq_tfe` pulses in that same cycle exactly when bit 0 (the error bit) of the captured status is set.
- R7: A set-device-bits frame is 8 bytes, with `out_is_sdb` high. Byte 0 is the error, byte 1 is 0x00, byte 2 is status AND 0x77, and byte 3 is 0x00. It pulses `irq_sdb`, and never `irq_d2h` or `irq_tfe`, in its `done` cycle.
- R8: Bytes 4..7 of a set-device-bits frame hold the completion mask little-endian, taken after this request's tags are ORed in. `mask_clr` empties the mask. When `mask_clr` and an accepted set-device-bits request fall on the same edge, the mask becomes exactly the new tags.
- R9: `done` is a one-cycle pulse in the cycle after the last byte's transfer. `busy` is high from the cycle after acceptance through the `done` cycle. Any request sampled while `busy` is high, including during the `done` cycle, is ignored.
- R10: When several requests arrive together at an idle, enabled block, `req_init` wins over `req_reg`, which wins over `req_sdb`. The losing requests have no effect, and that includes the completion mask.
- R11: Status, error, `glb_irq_pend`, `cmd_echo` and `is_optical` are sampled only at acceptance. Changes to them during emission do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Frame reception enabled for the port |
| req_init | input | 1 | Request the post-reset register frame |
| req_reg | input | 1 | Request a register frame echoing `cmd_echo` |
| req_sdb | input | 1 | Request a set-device-bits frame |
| sdb_tags | input | TAGS | Completed-tag bits ORed into the mask |
| mask_clr | input | 1 | Clear the running completion mask |
| is_optical | input | 1 | Attached device is optical (post-reset frame) |
| glb_irq_pend | input | 1 | Adapter-wide interrupt status is nonzero |
| sts_in | input | 8 | Current device status byte |
| err_in | input | 8 | Current device error byte |
| cmd_echo | input | 80 | Command frame bytes 4..13, byte 4 in bits 7:0 |
| busy | output | 1 | A frame is in progress; requests are ignored |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream consumer ready |
| out_offset | output | 5 | Byte offset within the frame |
| out_byte | output | 8 | Frame byte |
| out_is_sdb | output | 1 | Current frame is a set-device-bits frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| irq_d2h | output | 1 | Register-frame-received cause pulse |
| irq_tfe | output | 1 | Task-file-error cause pulse |
| irq_sdb | output | 1 | Set-device-bits cause pulse |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a mask clear and the acceptance of a set-device-bits request. The bench drives `mask_clr` and `req_sdb` on the same edge, after earlier tags have filled the mask. The frame's bytes 4..7 must then show only the new tags, and a later frame with zero tags confirms that the mask held that value. The second pair is a new request and the `done` cycle of the previous frame. The bench times a request to land exactly on that cycle and expects `busy` low on the next cycle with no second frame, judged against the behavioural reference on every clock.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  localparam int REG_LEN    = 20;
  localparam int SDB_LEN    = 8;
  localparam int OFF_W      = $clog2(REG_LEN);
  localparam int SDB_IW     = $clog2(SDB_LEN);
  localparam int ECHO_FIRST = 4;
  localparam int ECHO_N     = 10;
  localparam int ECHO_W     = ECHO_N * 8;
  localparam int MASK_W     = 32;
  localparam int MASK_BYTES = MASK_W / 8;
  localparam int MASK_FIRST = 4;
  localparam int ERR_BIT    = 0;
  localparam int IPEND_BIT  = 6;

  localparam logic [7:0] D2H_TYPE     = 8'h34;
  localparam logic [7:0] SDB_STS_KEEP = 8'h77;

  localparam int INIT_SEC_POS = 4;
  localparam int INIT_CNT_POS = 12;
  localparam int OPT_LO_POS   = 5;
  localparam int OPT_HI_POS   = 6;
  localparam logic [7:0] OPT_LO_VAL = 8'h14;
  localparam logic [7:0] OPT_HI_VAL = 8'hEB;

  localparam logic [OFF_W-1:0] REG_LAST = OFF_W'(REG_LEN - 1);
  localparam logic [OFF_W-1:0] SDB_LAST = OFF_W'(SDB_LEN - 1);

  typedef enum logic [1:0] {
    FK_REG  = 2'd0,
    FK_INIT = 2'd1,
    FK_SDB  = 2'd2
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } emit_state_e;

  // Echo field content of the frame sent after a port reset.
  function automatic logic [ECHO_W-1:0] init_echo(input logic optical);
    logic [ECHO_W-1:0] v;
    v = '0;
    v[(INIT_SEC_POS - ECHO_FIRST)*8 +: 8] = 8'h01;
    v[(INIT_CNT_POS - ECHO_FIRST)*8 +: 8] = 8'h01;
    if (optical) begin
      v[(OPT_LO_POS - ECHO_FIRST)*8 +: 8] = OPT_LO_VAL;
      v[(OPT_HI_POS - ECHO_FIRST)*8 +: 8] = OPT_HI_VAL;
    end
    return v;
  endfunction

endpackage

// File: rtl/sfg_arbiter.sv
module sfg_arbiter
  import sfg_pkg::*;
(
  input  logic        idle,
  input  logic        rx_en,
  input  logic        req_init,
  input  logic        req_reg,
  input  logic        req_sdb,
  output logic        accept,
  output frame_kind_e kind
);

  logic any_req;

  assign any_req = req_init | req_reg | req_sdb;
  assign accept  = idle & rx_en & any_req;

  // Fixed priority: post-reset frame, then register frame, then SDB.
  always_comb begin
    if (req_init)      kind = FK_INIT;
    else if (req_reg)  kind = FK_REG;
    else               kind = FK_SDB;
  end

endmodule

// File: rtl/sfg_done_mask.sv
module sfg_done_mask #(
  parameter int TAGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            add,
  input  logic [TAGS-1:0] tags,
  output logic [TAGS-1:0] mask_next
);

  logic [TAGS-1:0] mask_q;

  // Clear acts on the old value; tags of the same edge survive it.
  always_comb begin
    mask_next = clr ? '0 : mask_q;
    if (add) mask_next = mask_next | tags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next;
  end

endmodule

// File: rtl/sfg_reg_frame.sv
module sfg_reg_frame
  import sfg_pkg::*;
(
  input  logic [OFF_W-1:0]  idx,
  input  logic [7:0]        sts,
  input  logic [7:0]        err,
  input  logic              pend,
  input  logic [ECHO_W-1:0] echo,
  output logic [7:0]        byte_o
);

  logic [7:0] fb [REG_LEN];

  always_comb begin
    for (int k = 0; k < REG_LEN; k++) fb[k] = 8'h00;
    fb[0] = D2H_TYPE;
    fb[1][IPEND_BIT] = pend;
    fb[2] = sts;
    fb[3] = err;
    for (int k = 0; k < ECHO_N; k++) fb[ECHO_FIRST + k] = echo[k*8 +: 8];
  end

  assign byte_o = (idx <= REG_LAST) ? fb[idx] : 8'h00;

endmodule

// File: rtl/sfg_sdb_frame.sv
module sfg_sdb_frame
  import sfg_pkg::*;
(
  input  logic [OFF_W-1:0]  idx,
  input  logic [7:0]        sts,
  input  logic [7:0]        err,
  input  logic [MASK_W-1:0] mask,
  output logic [7:0]        byte_o
);

  logic [7:0] sb [SDB_LEN];

  assign sb[0] = err;
  assign sb[1] = 8'h00;
  assign sb[2] = sts & SDB_STS_KEEP;
  assign sb[3] = 8'h00;

  for (genvar g = 0; g < MASK_BYTES; g++) begin : g_mask_byte
    assign sb[MASK_FIRST + g] = mask[g*8 +: 8];
  end

  assign byte_o = (idx <= SDB_LAST) ? sb[idx[SDB_IW-1:0]] : 8'h00;

endmodule

// File: rtl/d2h_status_framer.sv
module d2h_status_framer
  import sfg_pkg::*;
#(
  parameter int TAGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             req_init,
  input  logic             req_reg,
  input  logic             req_sdb,
  input  logic [TAGS-1:0]  sdb_tags,
  input  logic             mask_clr,
  input  logic             is_optical,
  input  logic             glb_irq_pend,
  input  logic [7:0]       sts_in,
  input  logic [7:0]       err_in,
  input  logic [ECHO_W-1:0] cmd_echo,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_offset,
  output logic [7:0]       out_byte,
  output logic             out_is_sdb,
  output logic             done,
  output logic             irq_d2h,
  output logic             irq_tfe,
  output logic             irq_sdb
);

  emit_state_e       state_q;
  frame_kind_e       kind_q;
  logic [OFF_W-1:0]  idx_q;
  logic [7:0]        sts_q;
  logic [7:0]        err_q;
  logic              pend_q;
  logic [ECHO_W-1:0] echo_q;
  logic [MASK_W-1:0] snap_q;

  logic              acc;
  frame_kind_e       acc_kind;
  logic [TAGS-1:0]   mask_next;
  logic [OFF_W-1:0]  last_idx;
  logic [7:0]        reg_byte;
  logic [7:0]        sdb_byte;

  sfg_arbiter u_arb (
    .idle     (state_q == ST_IDLE),
    .rx_en    (rx_en),
    .req_init (req_init),
    .req_reg  (req_reg),
    .req_sdb  (req_sdb),
    .accept   (acc),
    .kind     (acc_kind)
  );

  sfg_done_mask #(.TAGS(TAGS)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mask_clr),
    .add       (acc && (acc_kind == FK_SDB)),
    .tags      (sdb_tags),
    .mask_next (mask_next)
  );

  assign last_idx = (kind_q == FK_SDB) ? SDB_LAST : REG_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= FK_REG;
      idx_q   <= '0;
      sts_q   <= 8'h00;
      err_q   <= 8'h00;
      pend_q  <= 1'b0;
      echo_q  <= '0;
      snap_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            state_q <= ST_EMIT;
            kind_q  <= acc_kind;
            idx_q   <= '0;
            sts_q   <= sts_in;
            err_q   <= err_in;
            pend_q  <= glb_irq_pend;
            echo_q  <= (acc_kind == FK_INIT) ? init_echo(is_optical) : cmd_echo;
            snap_q  <= MASK_W'(mask_next);
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (idx_q == last_idx) state_q <= ST_DONE;
            else                   idx_q   <= idx_q + OFF_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sfg_reg_frame u_reg (
    .idx    (idx_q),
    .sts    (sts_q),
    .err    (err_q),
    .pend   (pend_q),
    .echo   (echo_q),
    .byte_o (reg_byte)
  );

  sfg_sdb_frame u_sdb (
    .idx    (idx_q),
    .sts    (sts_q),
    .err    (err_q),
    .mask   (snap_q),
    .byte_o (sdb_byte)
  );

  assign busy       = (state_q != ST_IDLE);
  assign out_valid  = (state_q == ST_EMIT);
  assign out_offset = idx_q;
  assign out_is_sdb = (kind_q == FK_SDB);
  assign out_byte   = out_is_sdb ? sdb_byte : reg_byte;
  assign done       = (state_q == ST_DONE);
  assign irq_d2h    = done & ~out_is_sdb;
  assign irq_tfe    = irq_d2h & sts_q[ERR_BIT];
  assign irq_sdb    = done & out_is_sdb;

endmodule

// File: rtl/sfg_checker.sv
module sfg_checker
  import sfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFF_W-1:0] out_offset,
  input logic [7:0]       out_byte,
  input logic             out_is_sdb,
  input logic             done,
  input logic             irq_d2h,
  input logic             irq_tfe,
  input logic             irq_sdb
);

  logic [OFF_W-1:0] last_off;
  assign last_off = out_is_sdb ? SDB_LAST : REG_LAST;

  p_rx_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_byte)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_offset != last_off))
      |=> (out_valid && (out_offset == $past(out_offset) + OFF_W'(1))));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_valid && (out_offset == '0)));

  p_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_sdb && (out_offset == '0)) |-> (out_byte == D2H_TYPE));

  p_tfe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tfe |-> irq_d2h);

  p_d2h_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_d2h |-> (done && !out_is_sdb));

  p_sdb_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sdb |-> (done && out_is_sdb && !irq_d2h && !irq_tfe));

  p_last_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_offset == last_off)) |=> (done && !out_valid));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind d2h_status_framer sfg_checker u_sfg_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_offset (out_offset),
  .out_byte   (out_byte),
  .out_is_sdb (out_is_sdb),
  .done       (done),
  .irq_d2h    (irq_d2h),
  .irq_tfe    (irq_tfe),
  .irq_sdb    (irq_sdb)
);

// File: tb/test_d2h_status_framer.sv
`timescale 1ns/1ps
module test_d2h_status_framer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        req_init = 1'b0;
  logic        req_reg = 1'b0;
  logic        req_sdb = 1'b0;
  logic [31:0] sdb_tags = '0;
  logic        mask_clr = 1'b0;
  logic        is_optical = 1'b0;
  logic        glb_irq_pend = 1'b0;
  logic [7:0]  sts_in = 8'h00;
  logic [7:0]  err_in = 8'h00;
  logic [79:0] cmd_echo = '0;
  logic        out_ready = 1'b1;
  logic        busy, out_valid, out_is_sdb, done, irq_d2h, irq_tfe, irq_sdb;
  logic [4:0]  out_offset;
  logic [7:0]  out_byte;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit rdy_rand = 0;

  always #2.5 clk = ~clk;

  d2h_status_framer i_d2h_status_framer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .req_init(req_init), .req_reg(req_reg), .req_sdb(req_sdb),
    .sdb_tags(sdb_tags), .mask_clr(mask_clr), .is_optical(is_optical),
    .glb_irq_pend(glb_irq_pend), .sts_in(sts_in), .err_in(err_in),
    .cmd_echo(cmd_echo), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .out_byte(out_byte),
    .out_is_sdb(out_is_sdb), .done(done), .irq_d2h(irq_d2h),
    .irq_tfe(irq_tfe), .irq_sdb(irq_sdb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int              m_phase = 0;   // 0 idle, 1 emitting, 2 done cycle
  int              m_idx = 0;
  bit              m_sdb = 0;
  bit              m_init = 0;
  bit              m_tfe = 0;
  int unsigned     m_mask = 0;
  int unsigned     m_mask_new;
  bit              m_acc;
  byte unsigned    m_fr[$];
  byte unsigned    b;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_idx = 0; m_sdb = 0; m_init = 0; m_tfe = 0; m_mask = 0;
      m_fr.delete();
    end else begin
      m_acc = (m_phase == 0) && rx_en && (req_init || req_reg || req_sdb);
      m_mask_new = mask_clr ? 0 : m_mask;
      if (m_acc && !req_init && !req_reg) m_mask_new = m_mask_new | sdb_tags;
      if (m_phase == 1) begin
        if (out_ready) begin
          if (m_idx == m_fr.size() - 1) m_phase = 2;
          else m_idx++;
        end
      end else if (m_phase == 2) begin
        m_phase = 0;
      end else if (m_acc) begin
        m_fr.delete();
        if (req_init || req_reg) begin
          m_sdb = 0; m_init = req_init; m_tfe = sts_in[0];
          m_fr.push_back(8'h34);
          m_fr.push_back(glb_irq_pend ? 8'h40 : 8'h00);
          m_fr.push_back(sts_in);
          m_fr.push_back(err_in);
          for (int k = 4; k < 14; k++) begin
            if (req_init) begin
              b = 0;
              if (k == 4 || k == 12) b = 8'h01;
              if (is_optical && k == 5) b = 8'h14;
              if (is_optical && k == 6) b = 8'heb;
            end else begin
              b = cmd_echo[(k-4)*8 +: 8];
            end
            m_fr.push_back(b);
          end
          for (int k = 0; k < 6; k++) m_fr.push_back(8'h00);
        end else begin
          m_sdb = 1; m_init = 0; m_tfe = 0;
          m_fr.push_back(err_in);
          m_fr.push_back(8'h00);
          m_fr.push_back(sts_in & 8'h77);
          m_fr.push_back(8'h00);
          for (int k = 0; k < 4; k++) m_fr.push_back(m_mask_new[k*8 +: 8]);
        end
        m_idx = 0;
        m_phase = 1;
      end
      m_mask = m_mask_new;
    end
  end

  function automatic string byte_tag(input int off);
    if (m_sdb) return (off < 4) ? "R7 sdb byte" : "R8 mask byte";
    if (off >= 4 && off < 14) return m_init ? "R5 init byte" : "R4 echo byte";
    return "R3 header byte";
  endfunction

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && started) begin
      check("R9 busy", busy, m_phase != 0);
      check("R2 out_valid", out_valid, m_phase == 1);
      check("R9 done", done, m_phase == 2);
      check("R6 irq_d2h", irq_d2h, (m_phase == 2) && !m_sdb);
      check("R6 irq_tfe", irq_tfe, (m_phase == 2) && !m_sdb && m_tfe);
      check("R7 irq_sdb", irq_sdb, (m_phase == 2) && m_sdb);
      if (m_phase == 1) begin
        check("R2 out_offset", out_offset, m_idx);
        check(byte_tag(m_idx), out_byte, m_fr[m_idx]);
        check("R7 out_is_sdb", out_is_sdb, m_sdb);
      end
    end
  end

  always @(negedge clk) out_ready <= rdy_rand ? (($urandom % 3) != 0) : 1'b1;

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input bit ri, input bit rr, input bit rs, input logic [31:0] tags);
    @(negedge clk);
    req_init = ri; req_reg = rr; req_sdb = rs; sdb_tags = tags;
    @(negedge clk);
    req_init = 0; req_reg = 0; req_sdb = 0; sdb_tags = '0;
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    while (busy && g < 2000) begin
      @(negedge clk);
      g++;
    end
    tick(1);
  endtask

  initial begin
    tick(4);
    // reset state
    check("R9 reset busy", busy, 0);
    check("R2 reset out_valid", out_valid, 0);
    check("R9 reset done", done, 0);
    rst_n = 1'b1;
    started = 1;
    tick(2);

    // R1: requests with reception disabled are ignored
    fire(0, 1, 0, 0);
    tick(2);
    check("R1 reg ignored busy", busy, 0);
    fire(0, 0, 1, 32'h0000_0001);
    tick(2);
    check("R1 sdb ignored busy", busy, 0);
    rx_en = 1'b1;
    // R1/R8: mask must show only 0x2 (the ignored 0x1 never entered)
    sts_in = 8'h40; err_in = 8'h00;
    fire(0, 0, 1, 32'h0000_0002);
    wait_idle();

    // R3/R4: register frame, pending flag set, no error
    glb_irq_pend = 1'b1; sts_in = 8'h50; err_in = 8'h00;
    cmd_echo = 80'h1312_1110_0F0E_0D0C_0B0A;
    fire(0, 1, 0, 0);
    wait_idle();

    // R6: error bit set raises task-file-error cause
    glb_irq_pend = 1'b0; sts_in = 8'h51; err_in = 8'h04;
    cmd_echo = 80'hA5A5_5A5A_FFFF_0000_8001;
    fire(0, 1, 0, 0);
    wait_idle();

    // R5: post-reset frame, non-optical then optical
    sts_in = 8'h50; err_in = 8'h01; is_optical = 1'b0;
    fire(1, 0, 0, 0);
    wait_idle();
    is_optical = 1'b1; sts_in = 8'h51;
    fire(1, 0, 0, 0);
    wait_idle();

    // R7/R8: SDB frames accumulate, status masked with 0x77
    sts_in = 8'hFF; err_in = 8'h84;
    fire(0, 0, 1, 32'h0000_0400);
    wait_idle();
    fire(0, 0, 1, 32'h8000_0000);
    wait_idle();

    // R8: clear alone, then same-edge clear and SDB acceptance
    @(negedge clk); mask_clr = 1'b1;
    @(negedge clk); mask_clr = 1'b0;
    fire(0, 0, 1, 32'h0000_0010);
    wait_idle();
    @(negedge clk);
    mask_clr = 1'b1; req_sdb = 1'b1; sdb_tags = 32'h0001_0000;
    @(negedge clk);
    mask_clr = 1'b0; req_sdb = 1'b0; sdb_tags = '0;
    wait_idle();
    fire(0, 0, 1, 32'h0);   // R8: mask must read back as 0x0001_0000
    wait_idle();

    // R2: back-pressure on a register frame
    rdy_rand = 1; sts_in = 8'h58; cmd_echo = 80'h0102_0304_0506_0708_090A;
    fire(0, 1, 0, 0);
    wait_idle();
    fire(0, 0, 1, 32'h0000_0008);
    wait_idle();
    rdy_rand = 0;
    tick(2);

    // R9: request during emission and during the done cycle are ignored
    fire(0, 1, 0, 0);
    tick(3);
    fire(0, 0, 1, 32'h0000_0100);
    tick(14);
    fire(0, 0, 1, 32'h0000_0200);
    check("R9 request in done cycle ignored", busy, 0);
    fire(0, 0, 1, 32'h0);   // R9: neither ignored tag may appear
    wait_idle();

    // R10: simultaneous requests, init wins, SDB tags dropped
    is_optical = 1'b0;
    fire(1, 1, 1, 32'h0000_0020);
    wait_idle();
    fire(0, 1, 1, 32'h0000_0040);
    wait_idle();
    fire(0, 0, 1, 32'h0);   // R10: mask without 0x20 and 0x40
    wait_idle();

    // R11: inputs change during emission, frame keeps captured values
    sts_in = 8'h50; err_in = 8'h00; glb_irq_pend = 1'b1;
    cmd_echo = 80'h2222_2222_2222_2222_2222;
    fire(0, 1, 0, 0);
    sts_in = 8'h51; err_in = 8'hEE; glb_irq_pend = 1'b0;
    cmd_echo = 80'h9999_9999_9999_9999_9999;
    is_optical = 1'b1;
    wait_idle();
    tick(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule